// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that finishes each instruction within one clock period. Every cycle it fetches one word from a private instruction store, decodes it, reads two registers, runs the ALU and commits its result. The commit goes to the register bank, to a private data store, or to the program counter. The supported set has five register-to-register operations (add, subtract, and, or, signed less-than), word load, word store, branch-if-equal and an absolute jump.

Control is decoded in two steps. The 6-bit opcode yields a 2-bit operation class. For the register-to-register class, the 6-bit function field then picks the exact ALU operation. The jump target keeps the top four bits of the incremented PC and fills the remaining bits with the 26-bit instruction field shifted left by two.

Both stores are loaded from outside through one preload port while the core is held in reset. The same address lines read back any data-store word, so results can be inspected after a program has run.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the PC is held at 0. The first instruction after reset is fetched from instruction word 0.
- R2: Any instruction other than a taken branch or a jump makes the PC advance by 4 in the next cycle. Stores use word index PC[9:2] with the default depth.
- R3: Opcode 000000 is register-to-register, with sources rs=[25:21], rt=[20:16] and destination rd=[15:11]. Function 100000 adds, 100010 subtracts (rs-rt), 100100 ANDs and 100101 ORs.
- R4: Function 101010 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 100011 loads rt with the data word at byte address rs + sign-extended [15:0], indexed by address bits [9:2].
- R6: Opcode 101011 writes rt to the data word at rs + sign-extended [15:0] and writes no register.
- R7: Opcode 000100 branches when rs equals rt, to PC+4 + (sign-extended [15:0] << 2). Otherwise it falls through to PC+4.
- R8: Opcode 000010 sets the next PC to {PC+4[31:28], [25:0], 2'b00} and writes neither registers nor memory.
- R9: Register 0 always reads as 0. A write aimed at it has no effect.
- R10: With `pre_we` high, `pre_wdata` is written to word `pre_addr` of the instruction store when `pre_to_imem`=1, and of the data store when it is 0. `peek_rdata` shows data word `pre_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | Preload write strobe |
| pre_to_imem | input | 1 | Preload target: 1 instruction store, 0 data store |
| pre_addr | input | MEM_AW | Preload / peek word index |
| pre_wdata | input | XLEN | Preload word |
| peek_rdata | output | XLEN | Data-store word at `pre_addr` |
| pc_o | output | XLEN | Current program counter |

## Verification
The properties assume that every fetched word belongs to the supported set and that preloading happens only while reset is held. They also assume that all data addresses and branch or jump targets are word aligned and fall inside the store depth. A store's effect on registers is judged through its opcode alone. Each directed program follows these rules: it is loaded under reset, it uses only aligned offsets within the first 64 words, and it ends in a one-instruction loop. The core therefore never fetches unloaded or out-of-range code.

// File: rtl/sc_pkg.sv
// sc_pkg: encodings shared by the single-cycle core.
// Assumes the fixed 32-bit instruction format: opcode [31:26], funct [5:0].
package sc_pkg;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // ALU operation codes seen by the arithmetic unit
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // Operation class from the first decode level; 2'b11 is never produced
    typedef enum logic [1:0] {
        CLS_ADDR  = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    // Control word from the main decoder
    typedef struct packed {
        logic     dst_rd;   // 1: write rd, 0: write rt
        logic     b_imm;    // 1: ALU B is the sign-extended immediate
        logic     wb_mem;   // 1: write back data-store word
        logic     rf_we;
        logic     mem_rd;
        logic     mem_we;
        logic     branch;
        logic     jump;
        alu_cls_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
// sc_main_dec: first decode level. Maps the opcode to datapath controls
// and a 2-bit operation class. Unknown opcodes produce an all-quiet word.
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode to control word lookup
    always_comb begin
        ctrl     = '0;
        ctrl.cls = CLS_ADDR;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_imm  = 1'b1;
                ctrl.wb_mem = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.mem_rd = 1'b1;
                ctrl.cls    = CLS_ADDR;
            end
            OPC_STORE: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_we = 1'b1;
                ctrl.cls    = CLS_ADDR;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_CMP;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
// sc_alu_dec: second decode level. Refines the operation class with the
// function field. Unlisted function codes fall back to add.
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_op_e    op
);

    // Class plus function to ALU operation
    always_comb begin
        op = ALU_ADD;
        case (cls)
            CLS_ADDR: op = ALU_ADD;
            CLS_CMP:  op = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// sc_alu: combinational arithmetic/logic unit with zero and signed
// overflow flags. Less-than is signed and yields 0 or 1.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         ovf
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         lt;

    assign sum  = a + b;
    assign diff = a - b;
    assign lt   = $signed(a) < $signed(b);

    // Result select
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = sum;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = sum;
        endcase
    end

    // Signed overflow for add and subtract only
    always_comb begin
        case (op)
            ALU_ADD: ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            ALU_SUB: ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            default: ovf = 1'b0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// sc_regfile: two combinational read ports, one write port committed at
// the clock edge. Entry 0 is hard zero. Synchronous active-low reset clears all.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [NREG];

    // Register commit; entry 0 never written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with forced zero for entry 0
    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc_core.sv
// sc_core: single-cycle 32-bit core with separate instruction and data
// stores. The PC and the fetch run every cycle with no enable.
// Assumes preloading happens under reset and that all addresses are word aligned.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic              pre_to_imem,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_wdata,
    output logic [XLEN-1:0]   peek_rdata,
    output logic [XLEN-1:0]   pc_o
);

    localparam int MEM_WORDS = 1 << MEM_AW;
    localparam int RA_W      = 5;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y;
    logic [XLEN-1:0] dm_rdata, wb_data;
    logic [RA_W-1:0] f_rs, f_rt, f_rd, wr_addr;
    logic [MEM_AW-1:0] dm_idx;
    logic            alu_zero, alu_ovf, take_br, rf_wen, dm_wen;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic            unused_bits;

    // Fetch and field split
    assign instr  = imem[pc_q[MEM_AW+1:2]];
    assign f_rs   = instr[25:21];
    assign f_rt   = instr[20:16];
    assign f_rd   = instr[15:11];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls   (ctrl.cls),
        .funct (instr[5:0]),
        .op    (alu_op)
    );

    assign wr_addr = ctrl.dst_rd ? f_rd : f_rt;
    assign rf_wen  = rst_n & ctrl.rf_we;

    sc_regfile #(.W(XLEN), .NREG(32)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_wen),
        .waddr   (wr_addr),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    // Data store access and write-back select
    assign dm_idx   = alu_y[MEM_AW+1:2];
    assign dm_rdata = dmem[dm_idx];
    assign dm_wen   = rst_n & ctrl.mem_we;
    assign wb_data  = ctrl.wb_mem ? dm_rdata : alu_y;

    // Next-PC candidates and selection, jump over branch
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
    assign take_br    = ctrl.branch & alu_zero;

    always_comb begin
        if (ctrl.jump)   pc_next = jmp_target;
        else if (take_br) pc_next = br_target;
        else             pc_next = pc_plus4;
    end

    // Program counter update every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction store preload
    always_ff @(posedge clk) begin
        if (pre_we && pre_to_imem) imem[pre_addr] <= pre_wdata;
    end

    // Data store preload or core store
    always_ff @(posedge clk) begin
        if (pre_we && !pre_to_imem) dmem[pre_addr] <= pre_wdata;
        else if (dm_wen)            dmem[dm_idx]   <= rt_val;
    end

    assign peek_rdata = dmem[pre_addr];
    assign pc_o       = pc_q;

    assign unused_bits = ^{instr[10:6], alu_ovf, ctrl.mem_rd};

endmodule

// File: rtl/sc_core_chk.sv
// sc_core_chk: temporal checks on the core, attached by bind.
// Assumes only supported, aligned instructions are fetched.
module sc_core_chk
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] alu_y,
    input logic            rf_wen
);

    logic [5:0]      opc;
    logic [XLEN-1:0] off;
    assign opc = instr[31:26];
    assign off = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && opc != OPC_JUMP && !(opc == OPC_BEQ && rs_val == rt_val))
        |=> pc_q == $past(pc_q) + XLEN'(4)); // R2

    AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && opc == OPC_BEQ && rs_val == rt_val)
        |=> pc_q == $past(pc_q) + XLEN'(4) + $past(off)); // R7

    AST_JUMP_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && opc == OPC_JUMP)
        |=> pc_q == {$past(pc_q + XLEN'(4)) >> 28, $past(instr[25:0]), 2'b00}); // R8

    AST_JUMP_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_JUMP) |-> !rf_wen); // R8

    AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_STORE) |-> !rf_wen); // R6

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |-> rs_val == '0); // R9

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_REG && instr[5:0] == FN_SLT) |-> alu_y[XLEN-1:1] == '0); // R4

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_q   (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .alu_y  (alu_y),
    .rf_wen (rf_wen)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
// sc_core_bench: directed programs, one task per scenario.
module sc_core_bench;

    localparam int XLEN   = 32;
    localparam int MEM_AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pre_we = 1'b0;
    logic              pre_to_imem = 1'b0;
    logic [MEM_AW-1:0] pre_addr = '0;
    logic [XLEN-1:0]   pre_wdata = '0;
    logic [XLEN-1:0]   peek_rdata;
    logic [XLEN-1:0]   pc_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sc_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u_sc_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_we      (pre_we),
        .pre_to_imem (pre_to_imem),
        .pre_addr    (pre_addr),
        .pre_wdata   (pre_wdata),
        .peek_rdata  (peek_rdata),
        .pc_o        (pc_o)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'b000010, t};
    endfunction

    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BQ = 6'b000100;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pre_write(bit to_imem, int idx, logic [31:0] d);
        pre_we      = 1'b1;
        pre_to_imem = to_imem;
        pre_addr    = idx[MEM_AW-1:0];
        pre_wdata   = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic peek(int idx, output logic [31:0] v);
        pre_addr = idx[MEM_AW-1:0];
        #1;
        v = peek_rdata;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            pre_write(1'b1, i, 32'h0);
            pre_write(1'b0, i, 32'h0);
        end
    endtask

    task automatic run(int n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // R1, R2: reset value and sequential stepping
    task automatic t_reset_step();
        logic [31:0] v;
        enter_reset();
        check("R1", "pc in reset", pc_o, 32'h0);
        rst_n = 1'b1;
        check("R1", "pc at release", pc_o, 32'h0);
        @(negedge clk);
        check("R2", "pc step 1", pc_o, 32'h4);
        @(negedge clk);
        check("R2", "pc step 2", pc_o, 32'h8);
        repeat (3) @(negedge clk);
        check("R2", "pc step 5", pc_o, 32'h14);
        peek(0, v);
        check("R9", "nop to r0 leaves data", v, 32'h0);
    endtask

    // R3, R4, R9: register operations
    task automatic t_alu_ops();
        logic [31:0] v;
        enter_reset();
        pre_write(1'b0, 0, 32'd7);
        pre_write(1'b0, 1, 32'hFFFF_FFFD);
        pre_write(1'b0, 2, 32'h0F0F_00FF);
        pre_write(1'b0, 10, 32'h0000_DEAD);
        pre_write(1'b1, 0,  enc_i(LW, 5'd0, 5'd1, 16'd0));
        pre_write(1'b1, 1,  enc_i(LW, 5'd0, 5'd2, 16'd4));
        pre_write(1'b1, 2,  enc_i(LW, 5'd0, 5'd3, 16'd8));
        pre_write(1'b1, 3,  enc_r(5'd1, 5'd2, 5'd4, 6'b100000));
        pre_write(1'b1, 4,  enc_r(5'd1, 5'd2, 5'd5, 6'b100010));
        pre_write(1'b1, 5,  enc_r(5'd1, 5'd3, 5'd6, 6'b100100));
        pre_write(1'b1, 6,  enc_r(5'd2, 5'd3, 5'd7, 6'b100101));
        pre_write(1'b1, 7,  enc_r(5'd2, 5'd1, 5'd8, 6'b101010));
        pre_write(1'b1, 8,  enc_r(5'd1, 5'd2, 5'd9, 6'b101010));
        pre_write(1'b1, 9,  enc_i(SW, 5'd0, 5'd4, 16'd16));
        pre_write(1'b1, 10, enc_i(SW, 5'd0, 5'd5, 16'd20));
        pre_write(1'b1, 11, enc_i(SW, 5'd0, 5'd6, 16'd24));
        pre_write(1'b1, 12, enc_i(SW, 5'd0, 5'd7, 16'd28));
        pre_write(1'b1, 13, enc_i(SW, 5'd0, 5'd8, 16'd32));
        pre_write(1'b1, 14, enc_i(SW, 5'd0, 5'd9, 16'd36));
        pre_write(1'b1, 15, enc_r(5'd1, 5'd1, 5'd0, 6'b100000));
        pre_write(1'b1, 16, enc_i(SW, 5'd0, 5'd0, 16'd40));
        pre_write(1'b1, 17, enc_j(26'd17));
        run(30);
        peek(4, v);  check("R3", "add 7+-3", v, 32'd4);
        peek(5, v);  check("R3", "sub 7-(-3)", v, 32'd10);
        peek(6, v);  check("R3", "and", v, 32'd7);
        peek(7, v);  check("R3", "or", v, 32'hFFFF_FFFF);
        peek(8, v);  check("R4", "slt -3<7", v, 32'd1);
        peek(9, v);  check("R4", "slt 7<-3", v, 32'd0);
        peek(10, v); check("R9", "r0 after write", v, 32'd0);
        check("R8", "jump self-loop pc", pc_o, 32'd68);
    endtask

    // R5, R6: loads and stores with base and negative offset
    task automatic t_mem();
        logic [31:0] v;
        enter_reset();
        pre_write(1'b0, 3, 32'h1234_5678);
        pre_write(1'b0, 5, 32'd16);
        pre_write(1'b1, 0, enc_i(LW, 5'd0, 5'd2, 16'd20));
        pre_write(1'b1, 1, enc_i(LW, 5'd2, 5'd3, 16'hFFFC));
        pre_write(1'b1, 2, enc_i(SW, 5'd2, 5'd3, 16'd8));
        pre_write(1'b1, 3, enc_i(SW, 5'd0, 5'd3, 16'd32));
        pre_write(1'b1, 4, enc_i(SW, 5'd0, 5'd2, 16'd36));
        pre_write(1'b1, 5, enc_j(26'd5));
        run(15);
        peek(6, v); check("R5", "load via neg offset then store", v, 32'h1234_5678);
        peek(8, v); check("R6", "store left rt intact", v, 32'h1234_5678);
        peek(9, v); check("R6", "base reg intact", v, 32'd16);
        peek(5, v); check("R5", "source word unchanged", v, 32'd16);
    endtask

    // R7: taken, not-taken and backward branches
    task automatic t_branch();
        logic [31:0] v;
        enter_reset();
        pre_write(1'b0, 0, 32'd5);
        pre_write(1'b0, 1, 32'd5);
        pre_write(1'b0, 2, 32'd6);
        pre_write(1'b1, 0, enc_i(LW, 5'd0, 5'd1, 16'd0));
        pre_write(1'b1, 1, enc_i(LW, 5'd0, 5'd2, 16'd4));
        pre_write(1'b1, 2, enc_i(LW, 5'd0, 5'd3, 16'd8));
        pre_write(1'b1, 3, enc_i(BQ, 5'd1, 5'd2, 16'd2));
        pre_write(1'b1, 4, enc_i(SW, 5'd0, 5'd1, 16'd40));
        pre_write(1'b1, 5, enc_i(SW, 5'd0, 5'd1, 16'd44));
        pre_write(1'b1, 6, enc_i(BQ, 5'd1, 5'd3, 16'd1));
        pre_write(1'b1, 7, enc_i(SW, 5'd0, 5'd3, 16'd48));
        pre_write(1'b1, 8, enc_i(BQ, 5'd0, 5'd0, 16'hFFFF));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7", "taken branch target", pc_o, 32'd24);
        @(negedge clk);
        check("R7", "not-taken falls through", pc_o, 32'd28);
        repeat (10) @(negedge clk);
        check("R7", "backward branch loop", pc_o, 32'd32);
        peek(10, v); check("R7", "skipped store 1", v, 32'd0);
        peek(11, v); check("R7", "skipped store 2", v, 32'd0);
        peek(12, v); check("R7", "fall-through store", v, 32'd6);
    endtask

    // R8: jump splice and no side effects
    task automatic t_jump();
        logic [31:0] v;
        enter_reset();
        pre_write(1'b0, 0, 32'hCAFE_0001);
        pre_write(1'b1, 0, enc_i(LW, 5'd0, 5'd1, 16'd0));
        pre_write(1'b1, 1, enc_j(26'd4));
        pre_write(1'b1, 2, enc_i(SW, 5'd0, 5'd1, 16'd40));
        pre_write(1'b1, 3, enc_i(SW, 5'd0, 5'd1, 16'd44));
        pre_write(1'b1, 4, enc_i(SW, 5'd0, 5'd1, 16'd48));
        pre_write(1'b1, 5, enc_j(26'd5));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", "jump target", pc_o, 32'd16);
        repeat (4) @(negedge clk);
        check("R8", "jump loop", pc_o, 32'd20);
        peek(10, v); check("R8", "skipped by jump", v, 32'd0);
        peek(12, v); check("R8", "jump landed store", v, 32'hCAFE_0001);
    endtask

    // R10: preload routing and peek
    task automatic t_preload();
        logic [31:0] v;
        enter_reset();
        pre_write(1'b0, 20, 32'hA5A5_0F0F);
        pre_write(1'b1, 21, 32'h7777_7777);
        peek(20, v); check("R10", "peek data word", v, 32'hA5A5_0F0F);
        peek(21, v); check("R10", "imem write not in data", v, 32'h0);
    endtask

    initial begin
        t_reset_step();
        t_alu_ops();
        t_mem();
        t_branch();
        t_jump();
        t_preload();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule